// File: doc/BRIEF.md
# Co-Z Ladder Step Engine

This block performs a single step of a homogeneous Co-Z Montgomery ladder over a prime field. It takes the current projective state (X1, X2, Z), the x-coordinate of the base point, the curve constant a, the pre-scaled constant 4b, a precomputed value U and the modulus p. It returns the next state (X1', X2', Z'). All operands must already be reduced into [0, p). A surrounding ladder controller issues one start per step and collects the results when done goes high.

Inside the block, the field products are arranged in three dependency-free rounds. No product needs the result of another product in the same round. The products of a round run at the same time on a bank of twelve iterative bit-serial modular multipliers. A slot that a round does not use is not started. Between rounds the block forms sums, differences and doublings, each reduced back into [0, p).

Round one forms eight products: X2², a·Z, Z², X2·Z, 4b·Z, xP·Z, (X1+X2)·Z and X1·X2. Round two forms twelve products, M1 to M12, from the round-one results together with U, X2, Z and 4b. From these the block builds fX1 and V. Round three forms V·fX1, M9·V and the two halves of the X2' expression. The last modular addition then joins those two halves. The degree-6 factor of X2' is split into two degree-4 terms, and this split is what keeps X2' within three product rounds.

Top module: `coz_step`

## Requirements
- R1: While reset is asserted and after it is released, done is 0 and x1Out, x2Out and zOut are 0 until the first step completes.
- R2: x1Out = V·fX1 mod p, where fX1 = 2·M11 + 2·M10 + M8 − M12 and V = 4·M6 + 4·M7 + M8. Here M6 = X2·X2², M7 = (aZ)·(X2Z), M8 = (4bZ)·Z², M10 = ((X1+X2)Z)·(aZ), M11 = (X1+X2)·(X1X2) and M12 = U·(xPZ), all mod p.
- R3: zOut = (U·Z)·V mod p, with V as defined in R2.
- R4: x2Out = M1·(X2² − 2·M2) + M3·(M4 − 2·M5) mod p, where M1 = U·X2², M2 = (aZ)·Z, M3 = U·Z², M4 = (aZ)² and M5 = 4b·(X2Z).
- R5: done rises exactly 3·W+7 clock edges after the edge that accepts start, counting that edge as edge 0. With W = 32 this is edge 103.
- R6: Once done is high, done and all three outputs stay unchanged until start is sampled high. The edge that samples start clears done.
- R7: A start pulse sampled while a step is in progress is ignored. It changes neither the result nor the completion time of the step in progress.
- R8: All operands and the modulus are captured on the edge that accepts start. Changing them afterwards has no effect on the step in progress.
- R9: Every result lies in [0, p).
- R10: Results stay correct for a modulus close to 2^W (4294967291 at W = 32) and for operands at the extremes 0 and p−1, with no loss in the intermediate sums.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a step; accepted only when idle or done |
| modP | input | W | Prime modulus p |
| x1In | input | W | Ladder coordinate X1 |
| x2In | input | W | Ladder coordinate X2 |
| zIn | input | W | Shared coordinate Z |
| xpIn | input | W | Base-point x-coordinate |
| aIn | input | W | Curve constant a |
| b4In | input | W | Curve constant times four (4b) |
| uIn | input | W | Precomputed U |
| x1Out | output | W | Updated X1 |
| x2Out | output | W | Updated X2 |
| zOut | output | W | Updated Z |
| done | output | 1 | High from completion until the next accepted start |

## Verification
The results, together with the rise of done, are due 3·W+7 edges after the edge that accepts start: 103 edges at W = 32. The bench model accepts a start only when it has no step in flight. It counts edges from the accepting edge and switches its expected done flag and its expected results on exactly that edge. Before that edge it expects the previous values to hold.

Because the bench compares done and every output on each falling edge, a result that arrives one cycle early or one cycle late is reported, not only a wrong value. The cases that change inputs or pulse start again during a step test that nothing in the model's countdown or result moves.

// File: rtl/coz_pkg.sv
package coz_pkg;

  // multiplier slots in the bank and the slots each round occupies
  localparam int NSLOT   = 12;
  localparam int R1_USED = 8;
  localparam int R2_USED = 12;
  localparam int R3_USED = 4;

  typedef enum logic [1:0] {
    RND_ONE   = 2'd0,
    RND_TWO   = 2'd1,
    RND_THREE = 2'd2
  } roundT;

  // strobes from control to datapath
  typedef struct packed {
    logic  load;     // capture operands and modulus
    logic  go;       // start the multipliers of the current round
    roundT rnd;      // round selecting operand routing
    logic  capture;  // store products of rounds one and two
    logic  midLoad;  // register fX1 and V
    logic  finLoad;  // register final results
  } ctrlT;

endpackage

// File: rtl/coz_modmul.sv
// Bit-serial interleaved modular multiplier: W steps, MSB of opB first.
module coz_modmul #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         go,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic [W-1:0] modP,
  output logic [W-1:0] res,
  output logic         rdy
);

  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  aR, bR, accR;
  logic [CW-1:0] cntR;
  logic          busyR;

  logic [W:0]   twice, twiceSub, sum, sumSub;
  logic [W-1:0] dblRed, addRed, nextAcc;

  always_comb begin
    twice    = {accR, 1'b0};
    twiceSub = twice - {1'b0, modP};
    dblRed   = (twice >= {1'b0, modP}) ? twiceSub[W-1:0] : twice[W-1:0];
    sum      = {1'b0, dblRed} + {1'b0, aR};
    sumSub   = sum - {1'b0, modP};
    addRed   = (sum >= {1'b0, modP}) ? sumSub[W-1:0] : sum[W-1:0];
    nextAcc  = bR[W-1] ? addRed : dblRed;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      aR    <= '0;
      bR    <= '0;
      accR  <= '0;
      cntR  <= '0;
      busyR <= 1'b0;
      rdy   <= 1'b0;
    end else if (go) begin
      aR    <= opA;
      bR    <= opB;
      accR  <= '0;
      cntR  <= CW'(W);
      busyR <= 1'b1;
      rdy   <= 1'b0;
    end else if (busyR) begin
      accR <= nextAcc;
      bR   <= {bR[W-2:0], 1'b0};
      cntR <= cntR - CW'(1);
      if (cntR == CW'(1)) begin
        busyR <= 1'b0;
        rdy   <= 1'b1;
      end
    end
  end

  assign res = accR;

endmodule

// File: rtl/coz_datapath.sv
module coz_datapath
  import coz_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrlT         ctrl,
  input  logic [W-1:0] modP,
  input  logic [W-1:0] x1In,
  input  logic [W-1:0] x2In,
  input  logic [W-1:0] zIn,
  input  logic [W-1:0] xpIn,
  input  logic [W-1:0] aIn,
  input  logic [W-1:0] b4In,
  input  logic [W-1:0] uIn,
  output logic [W-1:0] x1Out,
  output logic [W-1:0] x2Out,
  output logic [W-1:0] zOut,
  output logic [W-1:0] pLatched,
  output logic         allRdy
);

  logic [W-1:0] pR, x1R, x2R, zR, xpR, aR, b4R, uR;
  logic [W-1:0] p1R [R1_USED];
  logic [W-1:0] mR  [NSLOT];
  logic [W-1:0] fx1R, vR;

  logic [W-1:0] opA [NSLOT];
  logic [W-1:0] opB [NSLOT];
  logic [W-1:0] res [NSLOT];
  logic [NSLOT-1:0] rdyV, enMask;

  function automatic logic [W-1:0] addM(input logic [W-1:0] x, input logic [W-1:0] y);
    logic [W:0] s, t;
    s = {1'b0, x} + {1'b0, y};
    t = s - {1'b0, pR};
    return (s >= {1'b0, pR}) ? t[W-1:0] : s[W-1:0];
  endfunction

  function automatic logic [W-1:0] subM(input logic [W-1:0] x, input logic [W-1:0] y);
    return (x >= y) ? (x - y) : (x + (pR - y));
  endfunction

  logic [W-1:0] sum12, fx1Next, vNext, x2Left, x2Right;

  always_comb begin
    sum12   = addM(x1R, x2R);
    fx1Next = subM(addM(addM(addM(mR[10], mR[10]), addM(mR[9], mR[9])), mR[7]), mR[11]);
    vNext   = addM(addM(addM(addM(mR[5], mR[5]), addM(mR[5], mR[5])),
                        addM(addM(mR[6], mR[6]), addM(mR[6], mR[6]))), mR[7]);
    x2Left  = subM(p1R[0], addM(mR[1], mR[1]));
    x2Right = subM(mR[3], addM(mR[4], mR[4]));
  end

  // operand routing per round
  always_comb begin
    for (int i = 0; i < NSLOT; i++) begin
      opA[i] = '0;
      opB[i] = '0;
    end
    enMask = '0;
    case (ctrl.rnd)
      RND_ONE: begin
        enMask = NSLOT'((1 << R1_USED) - 1);
        opA[0] = x2R;   opB[0] = x2R;
        opA[1] = aR;    opB[1] = zR;
        opA[2] = zR;    opB[2] = zR;
        opA[3] = x2R;   opB[3] = zR;
        opA[4] = b4R;   opB[4] = zR;
        opA[5] = xpR;   opB[5] = zR;
        opA[6] = sum12; opB[6] = zR;
        opA[7] = x1R;   opB[7] = x2R;
      end
      RND_TWO: begin
        enMask = NSLOT'((1 << R2_USED) - 1);
        opA[0]  = uR;     opB[0]  = p1R[0];
        opA[1]  = p1R[1]; opB[1]  = zR;
        opA[2]  = uR;     opB[2]  = p1R[2];
        opA[3]  = p1R[1]; opB[3]  = p1R[1];
        opA[4]  = b4R;    opB[4]  = p1R[3];
        opA[5]  = x2R;    opB[5]  = p1R[0];
        opA[6]  = p1R[1]; opB[6]  = p1R[3];
        opA[7]  = p1R[4]; opB[7]  = p1R[2];
        opA[8]  = uR;     opB[8]  = zR;
        opA[9]  = p1R[6]; opB[9]  = p1R[1];
        opA[10] = sum12;  opB[10] = p1R[7];
        opA[11] = uR;     opB[11] = p1R[5];
      end
      RND_THREE: begin
        enMask = NSLOT'((1 << R3_USED) - 1);
        opA[0] = vR;    opB[0] = fx1R;
        opA[1] = mR[8]; opB[1] = vR;
        opA[2] = mR[0]; opB[2] = x2Left;
        opA[3] = mR[2]; opB[3] = x2Right;
      end
      default: ;
    endcase
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    coz_modmul #(.W(W)) mul_i (
      .clk  (clk),
      .rstN (rstN),
      .go   (ctrl.go & enMask[g]),
      .opA  (opA[g]),
      .opB  (opB[g]),
      .modP (pR),
      .res  (res[g]),
      .rdy  (rdyV[g])
    );
  end

  assign allRdy = &(rdyV | ~enMask);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pR <= '0; x1R <= '0; x2R <= '0; zR <= '0;
      xpR <= '0; aR <= '0; b4R <= '0; uR <= '0;
      fx1R <= '0; vR <= '0;
      x1Out <= '0; x2Out <= '0; zOut <= '0;
      for (int i = 0; i < R1_USED; i++) p1R[i] <= '0;
      for (int i = 0; i < NSLOT; i++)   mR[i]  <= '0;
    end else begin
      if (ctrl.load) begin
        pR <= modP; x1R <= x1In; x2R <= x2In; zR <= zIn;
        xpR <= xpIn; aR <= aIn; b4R <= b4In; uR <= uIn;
      end
      if (ctrl.capture && ctrl.rnd == RND_ONE)
        for (int i = 0; i < R1_USED; i++) p1R[i] <= res[i];
      if (ctrl.capture && ctrl.rnd == RND_TWO)
        for (int i = 0; i < NSLOT; i++) mR[i] <= res[i];
      if (ctrl.midLoad) begin
        fx1R <= fx1Next;
        vR   <= vNext;
      end
      if (ctrl.finLoad) begin
        x1Out <= res[0];
        zOut  <= res[1];
        x2Out <= addM(res[2], res[3]);
      end
    end
  end

  assign pLatched = pR;

endmodule

// File: rtl/coz_ctrl.sv
module coz_ctrl
  import coz_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic start,
  input  logic allRdy,
  output ctrlT ctrl,
  output logic done
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_ISSUE, ST_WAIT, ST_MID, ST_DONE
  } stateT;

  stateT stateR, stateN;
  roundT rndR, rndN;

  always_comb begin
    stateN = stateR;
    rndN   = rndR;
    ctrl   = '{load: 1'b0, go: 1'b0, rnd: rndR, capture: 1'b0,
               midLoad: 1'b0, finLoad: 1'b0};
    case (stateR)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          ctrl.load = 1'b1;
          rndN      = RND_ONE;
          stateN    = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        ctrl.go = 1'b1;
        stateN  = ST_WAIT;
      end
      ST_WAIT: begin
        if (allRdy) begin
          case (rndR)
            RND_ONE: begin
              ctrl.capture = 1'b1;
              rndN         = RND_TWO;
              stateN       = ST_ISSUE;
            end
            RND_TWO: begin
              ctrl.capture = 1'b1;
              stateN       = ST_MID;
            end
            default: begin
              ctrl.finLoad = 1'b1;
              stateN       = ST_DONE;
            end
          endcase
        end
      end
      ST_MID: begin
        ctrl.midLoad = 1'b1;
        rndN         = RND_THREE;
        stateN       = ST_ISSUE;
      end
      default: stateN = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateR <= ST_IDLE;
      rndR   <= RND_ONE;
    end else begin
      stateR <= stateN;
      rndR   <= rndN;
    end
  end

  assign done = (stateR == ST_DONE);

endmodule

// File: rtl/coz_step.sv
module coz_step
  import coz_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [W-1:0] modP,
  input  logic [W-1:0] x1In,
  input  logic [W-1:0] x2In,
  input  logic [W-1:0] zIn,
  input  logic [W-1:0] xpIn,
  input  logic [W-1:0] aIn,
  input  logic [W-1:0] b4In,
  input  logic [W-1:0] uIn,
  output logic [W-1:0] x1Out,
  output logic [W-1:0] x2Out,
  output logic [W-1:0] zOut,
  output logic         done
);

  ctrlT         ctrl;
  logic         allRdy;
  logic [W-1:0] pLatched;

  coz_ctrl ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .allRdy (allRdy),
    .ctrl   (ctrl),
    .done   (done)
  );

  coz_datapath #(.W(W)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .modP     (modP),
    .x1In     (x1In),
    .x2In     (x2In),
    .zIn      (zIn),
    .xpIn     (xpIn),
    .aIn      (aIn),
    .b4In     (b4In),
    .uIn      (uIn),
    .x1Out    (x1Out),
    .x2Out    (x2Out),
    .zOut     (zOut),
    .pLatched (pLatched),
    .allRdy   (allRdy)
  );

endmodule

// File: rtl/coz_step_chk.sv
module coz_step_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rstN,
  input logic         start,
  input logic         done,
  input logic [W-1:0] x1Out,
  input logic [W-1:0] x2Out,
  input logic [W-1:0] zOut,
  input logic [W-1:0] pLatched
);

  localparam int LAT = 3 * W + 7;
  localparam int KW  = $clog2(LAT + 2);

  logic          inFlight;
  logic [KW-1:0] edgeCnt;
  logic          accepted;

  assign accepted = start && (!inFlight || done);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inFlight <= 1'b0;
      edgeCnt  <= '0;
    end else if (accepted) begin
      inFlight <= 1'b1;
      edgeCnt  <= '0;
    end else if (inFlight) begin
      if (done) inFlight <= 1'b0;
      else      edgeCnt  <= edgeCnt + KW'(1);
    end
  end

  // R5: completion lands on the fixed edge after acceptance
  assert_latency_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> (edgeCnt == KW'(LAT)));

  // R6: results and done hold while no start arrives
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> (done && $stable(x1Out) && $stable(x2Out) && $stable(zOut)));

  // R6: an accepted start clears done
  assert_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    (done && start) |=> !done);

  // R9: results are reduced
  assert_reduced_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ((x1Out < pLatched) && (x2Out < pLatched) && (zOut < pLatched)));

endmodule

bind coz_step coz_step_chk #(.W(W)) chk_i (.*);

// File: tb/coz_step_tb_top.sv
module coz_step_tb_top;

  localparam int W   = 32;
  localparam int LAT = 3 * W + 7;
  typedef longint unsigned u64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [W-1:0] modP = '0, x1In = '0, x2In = '0, zIn = '0;
  logic [W-1:0] xpIn = '0, aIn = '0, b4In = '0, uIn = '0;
  logic [W-1:0] x1Out, x2Out, zOut;
  logic done;

  always #2 clk = ~clk;

  coz_step #(.W(W)) dut_i (.*);

  int vectors = 0;
  int misses  = 0;
  bit finished = 0;
  string phase = "R1";

  // behavioural reference
  bit mBusy = 0;
  int mCnt  = 0;
  bit expDone = 0;
  u64 expX1 = 0, expX2 = 0, expZ = 0, mP = 1;
  u64 lP, lX1, lX2, lZ, lXp, lA, lB4, lU;

  function automatic u64 mm(u64 a, u64 b, u64 p); return (a * b) % p; endfunction
  function automatic u64 ad(u64 a, u64 b, u64 p); return (a + b) % p; endfunction
  function automatic u64 sb(u64 a, u64 b, u64 p); return (a + p - b) % p; endfunction

  task automatic ladderStep(input u64 p, x1, x2, z, xp, a, b4, u,
                            output u64 nx1, nx2, nz);
    u64 x2s, az, zs, x2z, bz, xpz, sz, x1x2, s12;
    u64 m1, m2, m3, m4, m5, m6, m7, m8, m9, m10, m11, m12, f, v;
    s12 = ad(x1, x2, p);
    x2s = mm(x2, x2, p); az = mm(a, z, p); zs = mm(z, z, p); x2z = mm(x2, z, p);
    bz = mm(b4, z, p); xpz = mm(xp, z, p); sz = mm(s12, z, p); x1x2 = mm(x1, x2, p);
    m1 = mm(u, x2s, p); m2 = mm(az, z, p); m3 = mm(u, zs, p); m4 = mm(az, az, p);
    m5 = mm(b4, x2z, p); m6 = mm(x2, x2s, p); m7 = mm(az, x2z, p); m8 = mm(bz, zs, p);
    m9 = mm(u, z, p); m10 = mm(sz, az, p); m11 = mm(s12, x1x2, p); m12 = mm(u, xpz, p);
    f = sb(ad(ad(mm(2, m11, p), mm(2, m10, p), p), m8, p), m12, p);
    v = ad(ad(mm(4, m6, p), mm(4, m7, p), p), m8, p);
    nx1 = mm(v, f, p);
    nz  = mm(m9, v, p);
    nx2 = ad(mm(m1, sb(x2s, mm(2, m2, p), p), p), mm(m3, sb(m4, mm(2, m5, p), p), p), p);
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mBusy <= 0; mCnt <= 0; expDone <= 0;
      expX1 <= 0; expX2 <= 0; expZ <= 0;
    end else if (start && !mBusy) begin
      mBusy <= 1; mCnt <= 1; expDone <= 0;
      lP <= u64'(modP); lX1 <= u64'(x1In); lX2 <= u64'(x2In); lZ <= u64'(zIn);
      lXp <= u64'(xpIn); lA <= u64'(aIn); lB4 <= u64'(b4In); lU <= u64'(uIn);
    end else if (mBusy) begin
      if (mCnt == LAT) begin
        u64 a1, a2, a3;
        ladderStep(lP, lX1, lX2, lZ, lXp, lA, lB4, lU, a1, a2, a3);
        expX1 <= a1; expX2 <= a2; expZ <= a3; mP <= lP;
        expDone <= 1; mBusy <= 0;
      end else begin
        mCnt <= mCnt + 1;
      end
    end
  end

  task automatic cmp(input string req, input u64 got, input u64 exp);
    vectors++;
    if (got !== exp) begin
      misses++;
      $display("FAIL %s [%s] got %0d expected %0d at %0t", req, phase, got, exp, $time);
    end
  endtask

  // compare on every falling edge
  always @(negedge clk) begin
    if (!finished) begin
      cmp(rstN ? "R5 done" : "R1 done", u64'(done), u64'(expDone));
      cmp(rstN ? "R2 x1Out" : "R1 x1Out", u64'(x1Out), expX1);
      cmp(rstN ? "R4 x2Out" : "R1 x2Out", u64'(x2Out), expX2);
      cmp(rstN ? "R3 zOut" : "R1 zOut", u64'(zOut), expZ);
      if (expDone) begin
        cmp("R9 reduced", u64'((u64'(x1Out) < mP) && (u64'(x2Out) < mP) && (u64'(zOut) < mP)), 1);
      end
    end
  end

  task automatic issue(input u64 p, x1, x2, z, xp, a, b4, u);
    @(negedge clk);
    modP = W'(p); x1In = W'(x1); x2In = W'(x2); zIn = W'(z);
    xpIn = W'(xp); aIn = W'(a); b4In = W'(b4); uIn = W'(u);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  function automatic u64 rv(u64 p); return u64'($urandom) % p; endfunction

  task automatic randomOp(input u64 p);
    issue(p, rv(p), rv(p), rv(p), rv(p), rv(p), rv(p), rv(p));
  endtask

  task automatic finishStep();
    repeat (LAT + 2) @(negedge clk);
  endtask

  task automatic summary();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  endtask

  localparam u64 P_SMALL = 1009;
  localparam u64 P_BIG   = 64'd4294967291;

  initial begin
    phase = "R1";
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    phase = "R2 R3 R4 small prime";
    for (int i = 0; i < 6; i++) begin randomOp(P_SMALL); finishStep(); end

    phase = "R10 large prime";
    for (int i = 0; i < 6; i++) begin randomOp(P_BIG); finishStep(); end

    phase = "R10 extremes";
    issue(P_BIG, 0, 0, 0, 0, 0, 0, 0); finishStep();
    issue(P_BIG, P_BIG-1, P_BIG-1, P_BIG-1, P_BIG-1, P_BIG-1, P_BIG-1, P_BIG-1); finishStep();
    issue(P_SMALL, P_SMALL-1, 0, P_SMALL-1, 1, P_SMALL-1, P_SMALL-1, 1); finishStep();

    phase = "R6 hold";
    randomOp(P_BIG); finishStep();
    repeat (20) @(negedge clk);

    phase = "R7 start while busy";
    randomOp(P_BIG);
    repeat (30) @(negedge clk);
    randomOp(P_SMALL);
    repeat (40) @(negedge clk);
    randomOp(P_BIG);
    finishStep();

    phase = "R8 inputs changed";
    randomOp(P_SMALL);
    repeat (5) @(negedge clk);
    modP = W'(P_BIG); x1In = W'(rv(P_BIG)); x2In = W'(rv(P_BIG)); zIn = W'(rv(P_BIG));
    xpIn = W'(rv(P_BIG)); aIn = W'(rv(P_BIG)); b4In = W'(rv(P_BIG)); uIn = W'(rv(P_BIG));
    finishStep();

    phase = "R5 R6 back-to-back";
    for (int i = 0; i < 3; i++) begin randomOp(P_BIG); repeat (LAT) @(negedge clk); end
    finishStep();

    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      misses++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      summary();
    end
  end

endmodule